// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block supervises data and control hazards for an in-order pipeline with six stages: fetch, decrypt, decode, execute, memory and writeback. It looks at the register specifiers and write enables that each stage presents. From these it picks, for the execute stage, the source of each ALU operand and the source of the store data. The source is either the register file, the result held in the EX/MEM register, or the value being written back.

When a load in execute is followed by a decode-stage instruction that reads the loaded register, the block holds the program counter and the front-end registers and injects a bubble into execute for one cycle. When execute resolves a branch or jump to a next block that differs from the statically predicted one, it flushes the fetch, decrypt and decode registers and redirects fetch to the resolved block. A flush takes precedence over a stall requested in the same cycle.

A small three-state controller (RUN, STALL, FLUSH) records which front-end action was taken in each cycle. The controller moves to FLUSH whenever a mispredict is resolved. Otherwise it moves to STALL when a load-use hazard exists, and to RUN in every other cycle. Event pulses for an external counter unit are driven from that state and from registered forward and prediction flags, so each pulse appears one cycle after its cause and lasts exactly one cycle.

Top module: `hzd_fwd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset with idle inputs, every event pulse output is 0 and every select output is 0.
- R2: Select code 2'd1 means EX/MEM, 2'd2 means writeback and 2'd0 means register file. An operand select is 1 when its operand is used and `mem_wen` is set with `mem_rd` equal to the operand register. Otherwise it is 2 when `wb_wen` is set with `wb_rd` equal to the operand register. In all remaining cases it is 0, including when the operand is not used.
- R3: When both EX/MEM and writeback target the operand register, the select is 2'd1 (EX/MEM wins).
- R4: Register 0 is never forwarded; its select is always 2'd0.
- R5: When `ex_is_store` is 1, `fwd_st` selects the store data source for `ex_rt` using the R2 rules and `fwd_b` is 2'd0. When `ex_is_store` is 0, `fwd_st` is 2'd0.
- R6: A load in execute (`ex_is_load` and `ex_wen`) with nonzero `ex_rd` that equals a used decode-stage source raises `pc_hold`, `fe_hold` and `ex_bubble` in the same cycle. No other case raises them.
- R7: When `br_valid` is 1 and `br_pred_blk` differs from `br_res_blk`, `flush_fe` and `redirect_en` are 1 and `redirect_blk` equals `br_res_blk`.
- R8: When `br_valid` is 1 and the prediction matches, or when `br_valid` is 0, `flush_fe` and `redirect_en` are 0.
- R9: When a mispredict and a load-use hazard occur in the same cycle, the flush proceeds and `pc_hold`, `fe_hold` and `ex_bubble` are all 0.
- R10: Event pulses appear one cycle after their cause and last one cycle. `ev_stall` follows a stall. `ev_mispredict` follows a flush. `ev_pred` follows any resolved branch or jump. `ev_fwd_mem` and `ev_fwd_wb` follow any select of 1 or 2 respectively. `ev_st_fwd` follows a nonzero `fwd_st`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | 5 | Decode-stage first source register |
| id_rt | input | 5 | Decode-stage second source register |
| id_rs_used | input | 1 | Decode instruction reads id_rs |
| id_rt_used | input | 1 | Decode instruction reads id_rt |
| ex_rs | input | 5 | Execute-stage first source register |
| ex_rt | input | 5 | Execute-stage second source register |
| ex_rs_used | input | 1 | Execute instruction reads ex_rs as ALU operand A |
| ex_rt_used | input | 1 | Execute instruction reads ex_rt as ALU operand B |
| ex_is_store | input | 1 | Execute instruction is a store (ex_rt is store data) |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_wen | input | 1 | Execute instruction writes ex_rd |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes mem_rd |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes wb_rd |
| br_valid | input | 1 | Execute resolves a branch or jump this cycle |
| br_pred_blk | input | 10 | Predicted next block |
| br_res_blk | input | 10 | Resolved next block |
| fwd_a | output | 2 | ALU operand A source select |
| fwd_b | output | 2 | ALU operand B source select |
| fwd_st | output | 2 | Store data source select |
| pc_hold | output | 1 | Hold the program counter |
| fe_hold | output | 1 | Hold fetch, decrypt and decode registers |
| ex_bubble | output | 1 | Inject a bubble into execute |
| flush_fe | output | 1 | Clear fetch, decrypt and decode registers |
| redirect_en | output | 1 | Restart fetch at redirect_blk |
| redirect_blk | output | 10 | Block at which fetch restarts |
| ev_stall | output | 1 | Stall event pulse |
| ev_mispredict | output | 1 | Mispredict event pulse |
| ev_pred | output | 1 | Resolved prediction event pulse |
| ev_fwd_mem | output | 1 | EX/MEM forward event pulse |
| ev_fwd_wb | output | 1 | Writeback forward event pulse |
| ev_st_fwd | output | 1 | Store data forward event pulse |

## Verification
The bench aims at cases where both later stages write the operand register, because a design that gives writeback priority would feed an older, stale value into the ALU. It checks that register 0 and unused operands are never forwarded, since a design that forwards them would pick up results destined for the hard-wired zero register or would overcount forward events. Load-use cases cover the destination-0 case, the unused-source case and the second-source case, where a loose detector would stall needlessly or miss a real hazard. A vector with a mispredict and a load-use hazard in the same cycle exposes a design that freezes the front end while also redirecting it. Back-to-back vectors show whether an event pulse lingers for more than one cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_WB    = 2'd2
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STALL = 2'd1,
        ST_FLUSH = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              use_en,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output fwd_sel_e          sel
);
    always_comb begin
        sel = FWD_RF;
        if (use_en && (src != '0)) begin
            if (mem_wen && (mem_rd == src)) begin
                sel = FWD_EXMEM;
            end else if (wb_wen && (wb_rd == src)) begin
                sel = FWD_WB;
            end
        end
    end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    output logic              hazard
);
    logic producer;
    always_comb begin
        producer = ex_is_load && ex_wen && (ex_rd != '0);
        hazard   = producer &&
                   ((id_rs_used && (id_rs == ex_rd)) ||
                    (id_rt_used && (id_rt == ex_rd)));
    end
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect #(
    parameter int BLK_W = 10
) (
    input  logic             br_valid,
    input  logic [BLK_W-1:0] pred_blk,
    input  logic [BLK_W-1:0] res_blk,
    output logic             mispredict,
    output logic [BLK_W-1:0] target_blk
);
    always_comb begin
        mispredict = br_valid && (pred_blk != res_blk);
        target_blk = res_blk;
    end
endmodule

// File: rtl/hzd_fwd_ctrl.sv
module hzd_fwd_ctrl
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int BLK_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic              ex_rs_used,
    input  logic              ex_rt_used,
    input  logic              ex_is_store,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    input  logic              br_valid,
    input  logic [BLK_W-1:0]  br_pred_blk,
    input  logic [BLK_W-1:0]  br_res_blk,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic [1:0]        fwd_st,
    output logic              pc_hold,
    output logic              fe_hold,
    output logic              ex_bubble,
    output logic              flush_fe,
    output logic              redirect_en,
    output logic [BLK_W-1:0]  redirect_blk,
    output logic              ev_stall,
    output logic              ev_mispredict,
    output logic              ev_pred,
    output logic              ev_fwd_mem,
    output logic              ev_fwd_wb,
    output logic              ev_st_fwd
);
    localparam int NUM_SRC = 3;

    logic [REG_AW-1:0] src_reg [NUM_SRC];
    logic              src_use [NUM_SRC];
    fwd_sel_e          src_sel [NUM_SRC];

    always_comb begin
        src_reg[0] = ex_rs;
        src_use[0] = ex_rs_used;
        src_reg[1] = ex_rt;
        src_use[1] = ex_rt_used && !ex_is_store;
        src_reg[2] = ex_rt;
        src_use[2] = ex_is_store;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hzd_fwd_sel #(.REG_AW(REG_AW)) u_sel (
            .src     (src_reg[g]),
            .use_en  (src_use[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (src_sel[g])
        );
    end

    logic lu_hazard;
    hzd_load_use #(.REG_AW(REG_AW)) u_lu (
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .id_rs_used (id_rs_used),
        .id_rt_used (id_rt_used),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .ex_is_load (ex_is_load),
        .hazard     (lu_hazard)
    );

    logic             mispredict;
    logic [BLK_W-1:0] target_blk;
    hzd_redirect #(.BLK_W(BLK_W)) u_redir (
        .br_valid   (br_valid),
        .pred_blk   (br_pred_blk),
        .res_blk    (br_res_blk),
        .mispredict (mispredict),
        .target_blk (target_blk)
    );

    logic stall_go;
    always_comb begin
        fwd_a        = src_sel[0];
        fwd_b        = src_sel[1];
        fwd_st       = src_sel[2];
        stall_go     = lu_hazard && !mispredict;
        pc_hold      = stall_go;
        fe_hold      = stall_go;
        ex_bubble    = stall_go;
        flush_fe     = mispredict;
        redirect_en  = mispredict;
        redirect_blk = target_blk;
    end

    ctl_state_e state_q, state_d;

    always_comb begin
        if (mispredict) begin
            state_d = ST_FLUSH;
        end else if (lu_hazard) begin
            state_d = ST_STALL;
        end else begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ev_stall      = 1'b0;
        ev_mispredict = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_STALL: ev_stall      = 1'b1;
            ST_FLUSH: ev_mispredict = 1'b1;
            default:  ;
        endcase
    end

    logic any_mem, any_wb;
    always_comb begin
        any_mem = 1'b0;
        any_wb  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            any_mem = any_mem || (src_sel[i] == FWD_EXMEM);
            any_wb  = any_wb  || (src_sel[i] == FWD_WB);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_pred    <= 1'b0;
            ev_fwd_mem <= 1'b0;
            ev_fwd_wb  <= 1'b0;
            ev_st_fwd  <= 1'b0;
        end else begin
            ev_pred    <= br_valid;
            ev_fwd_mem <= any_mem;
            ev_fwd_wb  <= any_wb;
            ev_st_fwd  <= (src_sel[2] != FWD_RF);
        end
    end
endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
    parameter int REG_AW = 5,
    parameter int BLK_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] ex_rs,
    input logic [REG_AW-1:0] ex_rt,
    input logic              ex_rs_used,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_wen,
    input logic              ex_is_store,
    input logic              br_valid,
    input logic [BLK_W-1:0]  br_pred_blk,
    input logic [BLK_W-1:0]  br_res_blk,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic [1:0]        fwd_st,
    input logic              pc_hold,
    input logic              fe_hold,
    input logic              ex_bubble,
    input logic              flush_fe,
    input logic              redirect_en,
    input logic [BLK_W-1:0]  redirect_blk,
    input logic              ev_stall,
    input logic              ev_mispredict,
    input logic              ev_pred
);
    assert_mem_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs_used && ex_rs != '0 && mem_wen && mem_rd == ex_rs) |-> (fwd_a == 2'd1));

    assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == '0) |-> (fwd_a == 2'd0));

    assert_store_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_is_store |-> (fwd_b == 2'd0));

    assert_no_store_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_store |-> (fwd_st == 2'd0));

    assert_stall_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (fe_hold && ex_bubble));

    assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_pred_blk != br_res_blk) |-> (flush_fe && redirect_en && redirect_blk == br_res_blk));

    assert_hit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid || br_pred_blk == br_res_blk) |-> (!flush_fe && !redirect_en));

    assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fe |-> (!pc_hold && !fe_hold && !ex_bubble));

    assert_stall_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> ev_stall);

    assert_flush_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fe |=> ev_mispredict);

    assert_pred_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> ev_pred);

    assert_event_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_stall, ev_mispredict}));
endmodule

bind hzd_fwd_ctrl hzd_fwd_chk #(.REG_AW(REG_AW), .BLK_W(BLK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ex_rs         (ex_rs),
    .ex_rt         (ex_rt),
    .ex_rs_used    (ex_rs_used),
    .mem_rd        (mem_rd),
    .mem_wen       (mem_wen),
    .ex_is_store   (ex_is_store),
    .br_valid      (br_valid),
    .br_pred_blk   (br_pred_blk),
    .br_res_blk    (br_res_blk),
    .fwd_a         (fwd_a),
    .fwd_b         (fwd_b),
    .fwd_st        (fwd_st),
    .pc_hold       (pc_hold),
    .fe_hold       (fe_hold),
    .ex_bubble     (ex_bubble),
    .flush_fe      (flush_fe),
    .redirect_en   (redirect_en),
    .redirect_blk  (redirect_blk),
    .ev_stall      (ev_stall),
    .ev_mispredict (ev_mispredict),
    .ev_pred       (ev_pred)
);

// File: tb/tb_hzd_fwd_ctrl.sv
`timescale 1ns/1ps
module tb_hzd_fwd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic       id_rs_used, id_rt_used, ex_rs_used, ex_rt_used;
    logic       ex_is_store, ex_is_load, ex_wen, mem_wen, wb_wen, br_valid;
    logic [9:0] br_pred_blk, br_res_blk, redirect_blk;
    logic [1:0] fwd_a, fwd_b, fwd_st;
    logic       pc_hold, fe_hold, ex_bubble, flush_fe, redirect_en;
    logic       ev_stall, ev_mispredict, ev_pred, ev_fwd_mem, ev_fwd_wb, ev_st_fwd;

    hzd_fwd_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rs_used(ex_rs_used), .ex_rt_used(ex_rt_used),
        .ex_is_store(ex_is_store), .ex_is_load(ex_is_load), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
        .br_valid(br_valid), .br_pred_blk(br_pred_blk), .br_res_blk(br_res_blk),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st),
        .pc_hold(pc_hold), .fe_hold(fe_hold), .ex_bubble(ex_bubble),
        .flush_fe(flush_fe), .redirect_en(redirect_en), .redirect_blk(redirect_blk),
        .ev_stall(ev_stall), .ev_mispredict(ev_mispredict), .ev_pred(ev_pred),
        .ev_fwd_mem(ev_fwd_mem), .ev_fwd_wb(ev_fwd_wb), .ev_st_fwd(ev_st_fwd)
    );

    typedef struct {
        string    req;
        logic [5:0] ev;
    } ev_item_t;

    ev_item_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        id_rs = 0; id_rt = 0; id_rs_used = 0; id_rt_used = 0;
        ex_rs = 0; ex_rt = 0; ex_rs_used = 0; ex_rt_used = 0;
        ex_is_store = 0; ex_is_load = 0; ex_rd = 0; ex_wen = 0;
        mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
        br_valid = 0; br_pred_blk = 0; br_res_blk = 0;
    endtask

    // Driver: inputs set by caller after the falling edge; checks same-cycle
    // outputs, then queues the event pulses expected after the next rising edge.
    task automatic step(input string req, input int ea, input int eb, input int es,
                        input bit estall, input bit eflush);
        ev_item_t it;
        #2;
        chk(req, "fwd_a", fwd_a, ea);
        chk(req, "fwd_b", fwd_b, eb);
        chk(req, "fwd_st", fwd_st, es);
        chk(req, "stall", {pc_hold, fe_hold, ex_bubble}, estall ? 7 : 0);
        chk(req, "flush", {flush_fe, redirect_en}, eflush ? 3 : 0);
        if (eflush) chk(req, "redirect_blk", redirect_blk, br_res_blk);
        it.req = req;
        it.ev = {estall, eflush, br_valid,
                 (ea == 1 || eb == 1 || es == 1),
                 (ea == 2 || eb == 2 || es == 2),
                 (es != 0)};
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares registered event pulses against the queued items.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                ev_item_t it;
                it = exp_q.pop_front();
                chk({it.req, " R10"}, "events",
                    {ev_stall, ev_mispredict, ev_pred, ev_fwd_mem, ev_fwd_wb, ev_st_fwd},
                    it.ev);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: pulses are cleared during reset
        chk("R1", "events_in_reset",
            {ev_stall, ev_mispredict, ev_pred, ev_fwd_mem, ev_fwd_wb, ev_st_fwd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1", 0, 0, 0, 0, 0);

        // R2: EX/MEM forward on operand A
        idle(); ex_rs = 3; ex_rs_used = 1; mem_rd = 3; mem_wen = 1;
        step("R2", 1, 0, 0, 0, 0);
        // R2: writeback forward on operand B
        idle(); ex_rt = 4; ex_rt_used = 1; wb_rd = 4; wb_wen = 1;
        step("R2", 0, 2, 0, 0, 0);
        // R2: unused operand not forwarded
        idle(); ex_rs = 3; ex_rs_used = 0; mem_rd = 3; mem_wen = 1;
        step("R2", 0, 0, 0, 0, 0);
        // R2: matching register but write enable off
        idle(); ex_rs = 9; ex_rs_used = 1; wb_rd = 9; wb_wen = 0;
        step("R2", 0, 0, 0, 0, 0);
        // R3: both stages target the same register
        idle(); ex_rs = 5; ex_rs_used = 1; ex_rt = 5; ex_rt_used = 1;
        mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1;
        step("R3", 1, 1, 0, 0, 0);
        // R4: register 0 never forwarded
        idle(); ex_rs = 0; ex_rs_used = 1; ex_rt = 0; ex_rt_used = 1;
        mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1;
        step("R4", 0, 0, 0, 0, 0);
        // R5: store data from EX/MEM
        idle(); ex_is_store = 1; ex_rt = 6; ex_rt_used = 1; mem_rd = 6; mem_wen = 1;
        step("R5", 0, 0, 1, 0, 0);
        // R5: store data from writeback, base from EX/MEM
        idle(); ex_is_store = 1; ex_rt = 7; ex_rt_used = 1; ex_rs = 8; ex_rs_used = 1;
        wb_rd = 7; wb_wen = 1; mem_rd = 8; mem_wen = 1;
        step("R5", 1, 0, 2, 0, 0);
        // R6: load-use on first source
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 7; id_rs = 7; id_rs_used = 1;
        step("R6", 0, 0, 0, 1, 0);
        // R6: load-use on second source
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 12; id_rt = 12; id_rt_used = 1;
        step("R6", 0, 0, 0, 1, 0);
        // R6: load into register 0 does not stall
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 0; id_rs = 0; id_rs_used = 1;
        step("R6", 0, 0, 0, 0, 0);
        // R6: source not used does not stall
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 11; id_rs = 11; id_rs_used = 0;
        step("R6", 0, 0, 0, 0, 0);
        // R6: non-load producer does not stall
        idle(); ex_is_load = 0; ex_wen = 1; ex_rd = 11; id_rs = 11; id_rs_used = 1;
        step("R6", 0, 0, 0, 0, 0);
        // R7: mispredict flushes and redirects
        idle(); br_valid = 1; br_pred_blk = 10'd10; br_res_blk = 10'd20;
        step("R7", 0, 0, 0, 0, 1);
        // R8: correct prediction leaves pipeline alone
        idle(); br_valid = 1; br_pred_blk = 10'd33; br_res_blk = 10'd33;
        step("R8", 0, 0, 0, 0, 0);
        // R8: differing blocks with no branch resolved
        idle(); br_valid = 0; br_pred_blk = 10'd1; br_res_blk = 10'd2;
        step("R8", 0, 0, 0, 0, 0);
        // R9: flush overrides simultaneous load-use stall
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 4; id_rs = 4; id_rs_used = 1;
        br_valid = 1; br_pred_blk = 10'd100; br_res_blk = 10'd512;
        step("R9", 0, 0, 0, 0, 1);
        // R10: back-to-back stalls then idle, pulses must drop
        idle(); ex_is_load = 1; ex_wen = 1; ex_rd = 2; id_rt = 2; id_rt_used = 1;
        step("R10", 0, 0, 0, 1, 0);
        idle();
        step("R10", 0, 0, 0, 0, 0);
        idle();
        step("R10", 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule